// File: doc/BRIEF.md
# Self-Starting Five-State Sequence Counter

This block is a 3-bit synchronous counter. It steps through a fixed cycle of five codes, and the cycle does not follow binary order. The state register drives the count output directly, so no decode logic sits between the flip-flops and the pins. Three of the eight codes are not in the cycle. Each of them has a fixed next state, and every one of them rejoins the cycle within two enabled clocks. The counter therefore recovers by itself from any power-up value. A combinational flag shows when the present code lies outside the cycle.

Every rising clock edge advances the state by one step while the count enable is high, and the state holds while it is low. A synchronous active-high reset loads the reset code. The reset code is a parameter whose default is 000.

The named states are ST_Z (000), ST_B (010), ST_C (011), ST_E (101), ST_F (110), and the stray codes ST_X1 (001), ST_X4 (100) and ST_X7 (111). The transitions are:
- cycle: ST_Z→ST_B→ST_C→ST_E→ST_F→ST_Z
- recovery: ST_X1→ST_F, ST_X4→ST_B, ST_X7→ST_X4

Top module: `seqctr_top`

## Requirements
- R1: On a rising edge with `rst` high, `count_q` becomes RESET_CODE (default 000) whatever `en` is.
- R2: With `en` high and `rst` low, `count_q` (bit 2 down to bit 0) steps 000→010→011→101→110→000 on successive rising edges.
- R3: With `en` low and `rst` low, `count_q` keeps its value across the edge, including when it holds 001, 100 or 111.
- R4: An enabled edge moves state 001 to 110.
- R5: An enabled edge moves state 100 to 010.
- R6: An enabled edge moves state 111 to 100. Every stray code is therefore back in the cycle after at most two enabled edges.
- R7: `off_cycle` is 1 in the same cycle exactly when `count_q` is 001, 100 or 111, and 0 for the five cycle codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to RESET_CODE |
| en | input | 1 | Count enable; state holds when low |
| count_q | output | 3 | Present state, which is also the count value |
| off_cycle | output | 1 | High while the state is a stray code |

## Verification
The bench builds four copies of the block. One keeps the default RESET_CODE of 000. The other three set it to 001, 100 and 111, so reset puts each stray code in place with no added load port. Each stray code can then be held with enable low, checked step by step along its recovery path, and timed until it rejoins the cycle. Random enable and reset patterns then drive all four copies against a reference model in the bench.

// File: rtl/seqctr_pkg.sv
package seqctr_pkg;
    localparam int CW = 3;

    typedef enum logic [CW-1:0] {
        ST_Z  = 3'b000,
        ST_X1 = 3'b001,
        ST_B  = 3'b010,
        ST_C  = 3'b011,
        ST_X4 = 3'b100,
        ST_E  = 3'b101,
        ST_F  = 3'b110,
        ST_X7 = 3'b111
    } seq_state_e;
endpackage

// File: rtl/seqctr_next.sv
module seqctr_next
    import seqctr_pkg::*;
(
    input  seq_state_e cur_i,
    output seq_state_e nxt_o
);
    always_comb begin
        unique case (cur_i)
            ST_Z:    nxt_o = ST_B;
            ST_B:    nxt_o = ST_C;
            ST_C:    nxt_o = ST_E;
            ST_E:    nxt_o = ST_F;
            ST_F:    nxt_o = ST_Z;
            ST_X1:   nxt_o = ST_F;
            ST_X4:   nxt_o = ST_B;
            ST_X7:   nxt_o = ST_X4;
            default: nxt_o = ST_Z;
        endcase
    end
endmodule

// File: rtl/seqctr_stray.sv
module seqctr_stray
    import seqctr_pkg::*;
(
    input  seq_state_e cur_i,
    output logic       stray_o
);
    always_comb begin
        unique case (cur_i)
            ST_X1, ST_X4, ST_X7:         stray_o = 1'b1;
            ST_Z, ST_B, ST_C, ST_E, ST_F: stray_o = 1'b0;
            default:                     stray_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/seqctr_top.sv
module seqctr_top
    import seqctr_pkg::*;
#(
    parameter logic [2:0] RESET_CODE = 3'b000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    output logic [2:0] count_q,
    output logic       off_cycle
);
    localparam seq_state_e RST_ST = seq_state_e'(RESET_CODE);

    seq_state_e state_q;
    seq_state_e state_nx;
    logic       stray;

    seqctr_next u_next (
        .cur_i (state_q),
        .nxt_o (state_nx)
    );

    seqctr_stray u_stray (
        .cur_i   (state_q),
        .stray_o (stray)
    );

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= RST_ST;
        else if (en)
            state_q <= state_nx;
    end

    always_comb begin
        count_q   = state_q;
        off_cycle = stray;
    end
endmodule

// File: rtl/seqctr_chk.sv
module seqctr_chk #(
    parameter logic [2:0] RESET_CODE = 3'b000
) (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic [2:0] count_q,
    input logic       off_cycle
);
    AST_RESET_LOAD: assert property (@(posedge clk) rst |=> count_q == RESET_CODE); // R1
    AST_STEP_Z: assert property (@(posedge clk) disable iff (rst) (en && count_q == 3'b000) |=> (rst || count_q == 3'b010)); // R2
    AST_STEP_C: assert property (@(posedge clk) disable iff (rst) (en && count_q == 3'b011) |=> (rst || count_q == 3'b101)); // R2
    AST_STEP_F: assert property (@(posedge clk) disable iff (rst) (en && count_q == 3'b110) |=> (rst || count_q == 3'b000)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !en |=> (rst || $stable(count_q))); // R3
    AST_FIX_X1: assert property (@(posedge clk) disable iff (rst) (en && count_q == 3'b001) |=> (rst || count_q == 3'b110)); // R4
    AST_FIX_X4: assert property (@(posedge clk) disable iff (rst) (en && count_q == 3'b100) |=> (rst || count_q == 3'b010)); // R5
    AST_FIX_X7: assert property (@(posedge clk) disable iff (rst) (en && off_cycle) |=> (rst || !off_cycle || count_q == 3'b100)); // R6
    AST_FLAG_CYCLE: assert property (@(posedge clk) disable iff (rst) (count_q == 3'b010 || count_q == 3'b101) |-> !off_cycle); // R7
endmodule

bind seqctr_top seqctr_chk #(.RESET_CODE(RESET_CODE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .count_q   (count_q),
    .off_cycle (off_cycle)
);

// File: tb/seqctr_top_tb.sv
module seqctr_top_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [2:0] q0, q1, q4, q7;
    logic f0, f1, f4, f7;
    int n_chk = 0;
    int n_bad = 0;
    logic [2:0] exp_q [4];
    logic [2:0] rvals [4] = '{3'b000, 3'b001, 3'b100, 3'b111};

    always #5 clk = ~clk;

    seqctr_top #(.RESET_CODE(3'b000)) u_dut    (.clk(clk), .rst(rst), .en(en), .count_q(q0), .off_cycle(f0));
    seqctr_top #(.RESET_CODE(3'b001)) u_dut_x1 (.clk(clk), .rst(rst), .en(en), .count_q(q1), .off_cycle(f1));
    seqctr_top #(.RESET_CODE(3'b100)) u_dut_x4 (.clk(clk), .rst(rst), .en(en), .count_q(q4), .off_cycle(f4));
    seqctr_top #(.RESET_CODE(3'b111)) u_dut_x7 (.clk(clk), .rst(rst), .en(en), .count_q(q7), .off_cycle(f7));

    function automatic logic [2:0] ref_next(input logic [2:0] s);
        case (s)
            3'b000: return 3'b010;
            3'b010: return 3'b011;
            3'b011: return 3'b101;
            3'b101: return 3'b110;
            3'b110: return 3'b000;
            3'b001: return 3'b110;
            3'b100: return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic logic ref_stray(input logic [2:0] s);
        return (s == 3'b001) || (s == 3'b100) || (s == 3'b111);
    endfunction

    function automatic logic [2:0] get_q(input int i);
        case (i)
            0: return q0;
            1: return q1;
            2: return q4;
            default: return q7;
        endcase
    endfunction

    function automatic logic get_f(input int i);
        case (i)
            0: return f0;
            1: return f1;
            2: return f4;
            default: return f7;
        endcase
    endfunction

    task automatic chk(input string req, input int i, input logic [3:0] act, input logic [3:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s inst%0d actual=%b expected=%b", req, i, act, expv);
        end
    endtask

    // one clock: drive at negedge, update model at edge, compare at next negedge
    task automatic step(input logic r, input logic e, input string req);
        rst = r;
        en  = e;
        @(posedge clk);
        for (int i = 0; i < 4; i++)
            exp_q[i] = r ? rvals[i] : (e ? ref_next(exp_q[i]) : exp_q[i]);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            chk(req, i, {1'b0, get_q(i)}, {1'b0, exp_q[i]});
            chk("R7", i, {3'b0, get_f(i)}, {3'b0, ref_stray(exp_q[i])});
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unused_seed;
        int steps;
        unused_seed = $urandom(1234);
        @(negedge clk);
        step(1'b1, 1'b1, "R1");
        step(1'b1, 1'b0, "R1");
        // hold stray codes with enable low
        step(1'b0, 1'b0, "R3");
        step(1'b0, 1'b0, "R3");
        // recovery paths: R4 (001), R5 (100), R6 (111) and main cycle R2
        step(1'b0, 1'b1, "R2_R4_R5_R6");
        chk("R4", 1, {1'b0, q1}, 4'b0110);
        chk("R5", 2, {1'b0, q4}, 4'b0010);
        chk("R6", 3, {1'b0, q7}, 4'b0100);
        step(1'b0, 1'b1, "R2_R6");
        chk("R6", 3, {1'b0, q7}, 4'b0010);
        chk("R6", 3, {3'b0, f7}, 4'b0000);
        // full main cycle on default instance
        for (int k = 0; k < 5; k++) step(1'b0, 1'b1, "R2");
        chk("R2", 0, {1'b0, q0}, 4'b0011);
        // bound on recovery in enabled clocks for each stray reset code
        for (int i = 1; i < 4; i++) begin
            step(1'b1, 1'b0, "R1");
            steps = 0;
            while (get_f(i) && steps < 3) begin
                step(1'b0, 1'b1, "R6");
                steps++;
            end
            chk("R6", i, {3'b0, get_f(i)}, 4'b0000);
            chk("R6", i, (steps <= 2) ? 4'd1 : 4'd0, 4'd1);
        end
        // reset beats enable
        step(1'b1, 1'b1, "R1");
        step(1'b0, 1'b0, "R3");
        // constrained random
        for (int k = 0; k < 400; k++)
            step(($urandom % 20) == 0, ($urandom % 4) != 0, "R2_R3");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule